// File: doc/BRIEF.md
# Ping-Pong Colour Lookup Table

This block applies a one-dimensional lookup table to every channel of a stream of RGB pixels. It keeps two complete tables, bank A and bank B, and each bank has a separate red, green and blue lane. Pixels arrive on a valid/ready input and leave on a valid/ready output one cycle later. In table mode each channel is replaced by the bank entry its upper bits address, with no interpolation. In bypass mode each channel passes through unchanged with the same one-cycle latency.

A simple host write port programs the block. One register holds the requested mode and active bank. A second holds the per-lane write mask and the bank that host loads go to. A third sets a load index, and a fourth is a data port that stores a value and then advances the index. The requested mode and bank take effect only on a frame-start strobe. The two "current" outputs report what is actually in use, so software can fill the idle bank while the other one serves pixels and then swap at a frame boundary without tearing.

Back-pressure follows the usual rule: the output register accepts a new pixel whenever it is empty or being drained in the same cycle, so `in_ready` equals `!out_valid || out_ready`. A stalled output holds its pixel unchanged. Host writes and frame strobes are never stalled.

Top module: `lut1d_pingpong`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `cur_mode` is 0 (bypass) and `cur_sel` is 0 (bank A). The write mask resets to 7, the host bank to A and the index to 0.
- R2: A mode value of 2 selects table lookup. The values 0, 1 and 3 all select bypass, in which each output channel equals its input channel.
- R3: The select field (control register bit 2) picks the bank used for lookups: 0 is bank A, 1 is bank B.
- R4: Writing the control register (address 0: mode in bits 1:0, select in bit 2) changes only the requested values. `cur_mode` and `cur_sel` copy them on the cycle after a `frame_start` pulse and hold otherwise.
- R5: The host-bank bit (write-config register at address 1, bit 3) chooses which bank data writes go to, 0 for A and 1 for B, whichever bank is active.
- R6: The write mask (address 1, bits 2:0) gates data writes per lane: bit 2 red, bit 1 green, bit 0 blue. A masked-off lane keeps its old entry.
- R7: Writing the index register (address 2) sets the entry the next data write (address 3) stores to. Each data write stores `host_wdata` at that entry in every unmasked lane of the host bank and then increments the index.
- R8: Each lane holds 2^ADDR_W + 1 entries (65 by default; the last is the end-base entry). An index write above that count clamps to it, and a data write with the index equal to the count stores nothing and leaves the index there.
- R9: In table mode the output channel equals the entry at the input channel's upper ADDR_W bits (bits 9:4 by default), and appears one cycle after the pixel is accepted, with the same latency as bypass.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the output pixel and `out_valid` hold.
- R11: A host write to the bank that is active is accepted and is seen by lookups of pixels accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that applies the requested mode and bank |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address: 0 control, 1 write config, 2 index, 3 data |
| host_wdata | input | PIX_W | Host write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | PIX_W | Input red channel |
| in_g | input | PIX_W | Input green channel |
| in_b | input | PIX_W | Input blue channel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_r | output | PIX_W | Output red channel |
| out_g | output | PIX_W | Output green channel |
| out_b | output | PIX_W | Output blue channel |
| cur_mode | output | 2 | Mode in effect |
| cur_sel | output | 1 | Bank in effect (0 A, 1 B) |

## Verification
The bench goes after the frame-boundary swap: a design that applied the control register at once would switch tables mid-frame, which shows up as a table value while `cur_mode` still reads bypass. It loads the last entry and then writes once more, and also clamps a large index, so a design that wrapped the index would overwrite entry 0 or 63 and corrupt a later lookup. Per-lane masks and the host-bank bit are exercised while the other bank is active, so a design that wrote the active bank or ignored the mask would return wrong red or green values. A stall with a second pixel waiting catches an output register that reloads or drops a pixel under back-pressure.

// File: rtl/lut1d_pkg.sv
package lut1d_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_WCFG  = 2'd1,
    REG_INDEX = 2'd2,
    REG_DATA  = 2'd3
  } reg_addr_e;

  localparam logic [1:0] MODE_LUT = 2'd2;
  localparam int         LANES    = 3;
  localparam int         BANKS    = 2;
endpackage

// File: rtl/lut1d_host_regs.sv
module lut1d_host_regs
  import lut1d_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int DEPTH = 65,
  parameter int IDX_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   host_we,
  input  logic [1:0]             host_addr,
  input  logic [PIX_W-1:0]       host_wdata,
  output logic [1:0]             cur_mode,
  output logic                   cur_sel,
  output logic [BANKS-1:0]       ram_we,
  output logic [LANES-1:0]       ram_mask,
  output logic [IDX_W-1:0]       ram_idx,
  output logic [PIX_W-1:0]       ram_wdata
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DEPTH);

  logic [1:0]       req_mode;
  logic             req_sel;
  logic [LANES-1:0] wmask;
  logic             host_bank;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_req;
  logic [IDX_W-1:0] idx_load;
  logic             data_wr;
  logic             data_ok;

  assign idx_req  = host_wdata[IDX_W-1:0];
  assign idx_load = (idx_req > IDX_END) ? IDX_END : idx_req;
  assign data_wr  = host_we && (host_addr == REG_DATA);
  assign data_ok  = data_wr && (idx < IDX_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_mode  <= '0;
      req_sel   <= 1'b0;
      cur_mode  <= '0;
      cur_sel   <= 1'b0;
      wmask     <= '1;
      host_bank <= 1'b0;
      idx       <= '0;
    end else begin
      if (frame_start) begin
        cur_mode <= req_mode;
        cur_sel  <= req_sel;
      end
      if (host_we) begin
        case (host_addr)
          REG_CTRL: begin
            req_mode <= host_wdata[1:0];
            req_sel  <= host_wdata[2];
          end
          REG_WCFG: begin
            wmask     <= host_wdata[2:0];
            host_bank <= host_wdata[3];
          end
          REG_INDEX: idx <= idx_load;
          default:   if (data_ok) idx <= idx + 1'b1;
        endcase
      end
    end
  end

  assign ram_we    = {data_ok && host_bank, data_ok && !host_bank};
  assign ram_mask  = wmask;
  assign ram_idx   = idx;
  assign ram_wdata = host_wdata;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_END); // R8
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx < IDX_END) |=> idx == $past(idx) + 1'b1); // R7
  AST_IDX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx == IDX_END) |=> idx == IDX_END); // R8
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cur_mode) && $stable(cur_sel))); // R4
  AST_CUR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cur_mode == $past(req_mode) && cur_sel == $past(req_sel))); // R4
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_we)); // R5
endmodule

// File: rtl/lut1d_bank.sv
module lut1d_bank
  import lut1d_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 65,
  parameter int IDX_W  = 7
) (
  input  logic                               clk,
  input  logic                               we,
  input  logic [LANES-1:0]                   wmask,
  input  logic [IDX_W-1:0]                   widx,
  input  logic [PIX_W-1:0]                   wdata,
  input  logic [LANES-1:0][ADDR_W-1:0]       raddr,
  output logic [LANES-1:0][PIX_W-1:0]        rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[l]) mem[widx] <= wdata;
    end

    assign rdata[l] = mem[IDX_W'(raddr[l])];
  end
endmodule

// File: rtl/lut1d_pix_stage.sv
module lut1d_pix_stage
  import lut1d_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   lut_en,
  input  logic                                   sel,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [LANES-1:0][PIX_W-1:0]            pix_in,
  output logic [LANES-1:0][ADDR_W-1:0]           raddr,
  input  logic [BANKS-1:0][LANES-1:0][PIX_W-1:0] rd,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [LANES-1:0][PIX_W-1:0]            pix_out
);
  logic [LANES-1:0][PIX_W-1:0] next_pix;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign raddr[l]    = pix_in[l][PIX_W-1 -: ADDR_W];
    assign next_pix[l] = lut_en ? rd[sel][l] : pix_in[l];
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pix_out   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) pix_out <= next_pix;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(pix_out))); // R10
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid); // R10
endmodule

// File: rtl/lut1d_pingpong.sv
module lut1d_pingpong
  import lut1d_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [PIX_W-1:0] host_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b,
  output logic [1:0]       cur_mode,
  output logic             cur_sel
);
  localparam int DEPTH = (1 << ADDR_W) + 1;
  localparam int IDX_W = $clog2(DEPTH + 1);

  logic [BANKS-1:0]                   ram_we;
  logic [LANES-1:0]                   ram_mask;
  logic [IDX_W-1:0]                   ram_idx;
  logic [PIX_W-1:0]                   ram_wdata;
  logic [LANES-1:0][ADDR_W-1:0]       raddr;
  logic [BANKS-1:0][LANES-1:0][PIX_W-1:0] rd;
  logic [LANES-1:0][PIX_W-1:0]        pix_in;
  logic [LANES-1:0][PIX_W-1:0]        pix_out;

  assign pix_in = {in_r, in_g, in_b};
  assign {out_r, out_g, out_b} = pix_out;

  lut1d_host_regs #(.PIX_W(PIX_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .cur_mode   (cur_mode),
    .cur_sel    (cur_sel),
    .ram_we     (ram_we),
    .ram_mask   (ram_mask),
    .ram_idx    (ram_idx),
    .ram_wdata  (ram_wdata)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    lut1d_bank #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
      .clk  (clk),
      .we   (ram_we[b]),
      .wmask(ram_mask),
      .widx (ram_idx),
      .wdata(ram_wdata),
      .raddr(raddr),
      .rdata(rd[b])
    );
  end

  lut1d_pix_stage #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_pix (
    .clk      (clk),
    .rst_n    (rst_n),
    .lut_en   (cur_mode == MODE_LUT),
    .sel      (cur_sel),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .pix_in   (pix_in),
    .raddr    (raddr),
    .rd       (rd),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .pix_out  (pix_out)
  );

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cur_mode != MODE_LUT && !frame_start)
      |=> (out_valid && out_r == $past(in_r) && out_b == $past(in_b))); // R2
endmodule

// File: tb/tb_lut1d_pingpong.sv
module tb_lut1d_pingpong;
  localparam int PW = 10;
  localparam int NE = 65;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_addr = '0;
  logic [PW-1:0] host_wdata = '0;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [PW-1:0] out_r, out_g, out_b;
  logic [1:0] cur_mode;
  logic cur_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lut1d_pingpong dut (.*);

  // reference model state
  int mref [2][3][NE];
  int m_pm, m_ps, m_cm, m_cs, m_mask, m_hb, m_idx;
  bit m_ov;
  int m_o [3];

  function automatic int fa(int i);  return (i * 7 + 3) % 1024; endfunction
  function automatic int fbr(int i); return 1023 - i; endfunction
  function automatic int fbg(int i); return (i * 3) % 1024; endfunction
  function automatic int fbb(int i); return i + 500; endfunction

  function automatic int mlook(int lane, int v);
    if (m_cm == 2) return mref[m_cs][lane][v >> 4];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pm = 0; m_ps = 0; m_cm = 0; m_cs = 0; m_mask = 7; m_hb = 0; m_idx = 0; m_ov = 0;
    end else begin
      if (!m_ov || out_ready) begin
        m_ov = in_valid;
        if (in_valid) begin
          m_o[2] = mlook(2, int'(in_r));
          m_o[1] = mlook(1, int'(in_g));
          m_o[0] = mlook(0, int'(in_b));
        end
      end
      if (frame_start) begin m_cm = m_pm; m_cs = m_ps; end
      if (host_we) begin
        case (host_addr)
          2'd0: begin m_pm = int'(host_wdata[1:0]); m_ps = int'(host_wdata[2]); end
          2'd1: begin m_mask = int'(host_wdata[2:0]); m_hb = int'(host_wdata[3]); end
          2'd2: m_idx = (int'(host_wdata[6:0]) > NE) ? NE : int'(host_wdata[6:0]);
          default: if (m_idx < NE) begin
            for (int l = 0; l < 3; l++)
              if (m_mask[l]) mref[m_hb][l][m_idx] = int'(host_wdata);
            m_idx++;
          end
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, away from the clock edges
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk("R10 out_valid", out_valid, m_ov);
      chk("R10 in_ready", in_ready, !m_ov || out_ready);
      chk("R4 cur_mode", cur_mode, m_cm);
      chk("R4 cur_sel", cur_sel, m_cs);
      if (m_ov) begin
        chk("R9 out_r", out_r, m_o[2]);
        chk("R9 out_g", out_g, m_o[1]);
        chk("R9 out_b", out_b, m_o[0]);
      end
    end
  end

  task automatic host(input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'(a); host_wdata = PW'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // drive one pixel; returns with the result on the output register
  task automatic send_pix(input int r, input int g, input int b);
    @(negedge clk);
    in_valid = 1'b1; in_r = PW'(r); in_g = PW'(g); in_b = PW'(b);
    @(negedge clk);
    in_valid = 1'b0;
    #5;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 cur_mode", cur_mode, 0);
    chk("R1 cur_sel", cur_sel, 0);

    send_pix(677, 100, 1023);
    chk("R9 bypass r", out_r, 677);
    chk("R9 bypass b", out_b, 1023);

    // bank A, all lanes at once, plus one write past the end
    host(1, 7);
    host(2, 0);
    for (int i = 0; i < NE; i++) host(3, fa(i));
    host(3, 999);
    // bank B, one lane at a time
    host(1, 8 | 4); host(2, 0); for (int i = 0; i < NE; i++) host(3, fbr(i));
    host(1, 8 | 2); host(2, 0); for (int i = 0; i < NE; i++) host(3, fbg(i));
    host(1, 8 | 1); host(2, 0); for (int i = 0; i < NE; i++) host(3, fbb(i));
    host(1, 8 | 7); host(2, 100); host(3, 555);

    host(0, 2);
    send_pix(677, 100, 1023);
    chk("R4 no swap before frame", out_r, 677);
    chk("R4 cur_mode before frame", cur_mode, 0);
    pulse_frame();
    #5;
    chk("R4 cur_mode after frame", cur_mode, 2);

    send_pix(677, 100, 1023);
    chk("R9 lut r", out_r, fa(42));
    chk("R9 lut g", out_g, fa(6));
    chk("R8 last entry kept", out_b, fa(63));
    send_pix(0, 15, 16);
    chk("R8 entry 0 kept", out_r, fa(0));
    chk("R9 lut g low", out_g, fa(0));
    chk("R9 lut b", out_b, fa(1));

    host(0, 3); pulse_frame();
    send_pix(321, 5, 900);
    chk("R2 mode 3 bypass", out_r, 321);
    host(0, 1); pulse_frame();
    send_pix(322, 6, 901);
    chk("R2 mode 1 bypass", out_g, 6);

    host(0, 2 | 4); pulse_frame();
    send_pix(677, 100, 1023);
    chk("R3 bank B r", out_r, fbr(42));
    chk("R6 bank B g lane", out_g, fbg(6));
    chk("R6 bank B b lane", out_b, fbb(63));
    send_pix(0, 0, 0);
    chk("R8 clamped write ignored", out_r, fbr(0));

    // host bank A while B is active
    host(1, 7); host(2, 5); host(3, 77);
    send_pix(80, 80, 80);
    chk("R5 active bank untouched", out_r, fbr(5));
    // write into the active bank, red lane only, two steps
    host(1, 8 | 4); host(2, 5); host(3, 321); host(3, 322);
    send_pix(80, 80, 96);
    chk("R11 active bank write", out_r, 321);
    chk("R6 masked lane kept", out_g, fbg(5));
    chk("R7 index advanced", out_b, fbb(6));
    send_pix(96, 0, 0);
    chk("R7 second entry", out_r, 322);

    host(0, 2); pulse_frame();
    send_pix(80, 0, 0);
    chk("R5 host bank A written", out_r, 77);

    // back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_r = PW'(160); in_g = '0; in_b = '0;
    @(negedge clk);
    in_r = PW'(176);
    #5;
    chk("R10 stalled in_ready", in_ready, 0);
    repeat (2) @(negedge clk);
    #5;
    chk("R10 stalled hold", out_r, fa(10));
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #5;
    chk("R10 second pixel after stall", out_r, fa(11));

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule